// File: doc/BRIEF.md
# Interrupt Status Coalescing Controller

This block keeps the sticky interrupt status and the per-event enables of a device controller and drives a single registered interrupt request toward the CPU. Single-cycle event pulses from the controller core latch into a nine-bit status word. Software reads the status, enable and command words over a small register bus. It acknowledges an event by writing a one to its status bit.

Completion and error events can be coalesced. A hold-off field in the command word gives a number of microframes. The first completion or error event arms a counter. That counter advances on the externally supplied microframe tick. Until the count is reached, those two status bits stay latched but do not raise the interrupt. All other events, such as bus reset, port change and suspend, reach the interrupt line with no hold-off. The bus-reset status bit can be read at any time, whatever the enables hold, so software can use it to abort a polling loop.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset the status, enable and command words all read 0 and `irq_o` is low.
- R2: A pulse on `ev_pulse[i]` sets status bit i, and the bit reads back as 1 from register address 0 in the cycle after the pulse. The bit positions are: 0 completion, 1 error, 2 port change, 3 frame rollover, 4 system error, 5 async advance, 6 bus reset, 7 start of frame, 8 suspend. Bits 0 and 1 are the delayable pair.
- R3: A write to address 0 clears every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is registered. It goes high one cycle after an enabled, non-held status bit becomes set. It goes low one cycle after the last such bit is cleared.
- R6: The enable word lives at address 1 and uses the status bit positions. A set status bit whose enable is 0 does not raise `irq_o`, and it stays readable at address 0. This includes bus reset (bit 6).
- R7: The hold-off count is command word bits 23:16, and the command word lives at address 2 and reads back as written. A count of 0 lets completion and error events raise `irq_o` with no delay.
- R8: With a count N > 0, a completion or error event arms the counter. Bits 0 and 1 reach `irq_o` only after N microframe ticks have been seen since arming. The interrupt rises one cycle after the tick that reaches N.
- R9: Events other than completion and error raise `irq_o` at once when enabled, even while the hold-off counter is running.
- R10: Once released, the hold-off stays open until status bits 0 and 1 are both clear. A later completion or error event then arms a new hold-off.
- R11: Microframe ticks that arrive while no hold-off is armed do not count toward a later hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 9 | One-cycle event pulses from the controller core |
| uframe_tick | input | 1 | One-cycle pulse per microframe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register select: 0 status, 1 enable, 2 command |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 2-bit register address, and an 8-bit hold-off field at bit 16. With these values the full command word read-back and every legal hold-off count can be reached. The directed tests program hold-off counts of 0, 2 and 4. This is enough to observe the arming edge, the exact tick on which the interrupt is released, and bypassing events arriving mid-window, all within a few dozen cycles.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int EV_W = 9;

    localparam int EV_XFER   = 0;
    localparam int EV_ERR    = 1;
    localparam int EV_PORT   = 2;
    localparam int EV_ROLL   = 3;
    localparam int EV_SYSERR = 4;
    localparam int EV_ASYNC  = 5;
    localparam int EV_BUSRST = 6;
    localparam int EV_SOF    = 7;
    localparam int EV_SUSP   = 8;

    // events subject to the microframe hold-off
    localparam logic [EV_W-1:0] DLY_MASK = EV_W'((1 << EV_XFER) | (1 << EV_ERR));

    typedef enum logic [1:0] {
        RSEL_STATUS = 2'd0,
        RSEL_ENABLE = 2'd1,
        RSEL_CMD    = 2'd2,
        RSEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int EV_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_i,
    input  logic            clr_en_i,
    input  logic [EV_W-1:0] clr_mask_i,
    output logic [EV_W-1:0] status_o
);

    logic [EV_W-1:0] status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (clr_en_i) begin
            status_d = status_d & ~clr_mask_i;
        end
        // a new event overrides a simultaneous acknowledge
        status_d = status_d | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_i,
    input  logic             dly_ev_i,
    input  logic             dly_pend_i,
    input  logic             tick_i,
    output logic             open_o
);

    localparam int CW = THR_W + 1;

    typedef struct packed {
        logic             armed;
        logic             met;
        logic [THR_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic idle_ok;
    logic [CW-1:0] cnt_next;

    always_comb begin
        s_d      = s_q;
        cnt_next = {1'b0, s_q.cnt} + CW'(1);
        idle_ok  = !s_q.armed && (!s_q.met || !dly_pend_i);

        if (s_q.met && !dly_pend_i) begin
            s_d.met = 1'b0;
        end

        if (s_q.armed && tick_i) begin
            if (cnt_next >= {1'b0, thr_i}) begin
                s_d.armed = 1'b0;
                s_d.met   = 1'b1;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = cnt_next[THR_W-1:0];
            end
        end

        if (dly_ev_i && idle_ok && (thr_i != '0)) begin
            s_d.armed = 1'b1;
            s_d.met   = 1'b0;
            s_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open_o = (thr_i == '0) || s_q.met;

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int              EV_W     = 9,
    parameter logic [EV_W-1:0] DLY_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] status_i,
    input  logic [EV_W-1:0] enable_i,
    input  logic            open_i,
    output logic            irq_o
);

    logic [EV_W-1:0] vis;
    logic irq_d, irq_q;

    for (genvar i = 0; i < EV_W; i++) begin : g_vis
        if (DLY_MASK[i]) begin : g_held
            assign vis[i] = open_i;
        end else begin : g_direct
            assign vis[i] = 1'b1;
        end
    end

    always_comb begin
        irq_d = |(status_i & enable_i & vis);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irq_coal_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32,
    parameter int THR_W   = 8,
    parameter int THR_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_W-1:0]   ev_pulse,
    input  logic              uframe_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(RSEL_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(RSEL_ENABLE);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(RSEL_CMD);

    typedef struct packed {
        logic [EV_W-1:0]   enable;
        logic [DATA_W-1:0] cmd;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [EV_W-1:0]  status_w;
    logic [EV_W-1:0]  enable_w;
    logic [THR_W-1:0] thr_w;
    logic             open_w;
    logic             clr_en_w;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we && reg_addr == A_ENABLE) begin
            cfg_d.enable = reg_wdata[EV_W-1:0];
        end
        if (reg_we && reg_addr == A_CMD) begin
            cfg_d.cmd = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_w = cfg_q.enable;
    assign thr_w    = cfg_q.cmd[THR_LSB +: THR_W];
    assign clr_en_w = reg_we && (reg_addr == A_STATUS);

    always_comb begin
        if (reg_addr == A_STATUS) begin
            reg_rdata = DATA_W'(status_w);
        end else if (reg_addr == A_ENABLE) begin
            reg_rdata = DATA_W'(cfg_q.enable);
        end else if (reg_addr == A_CMD) begin
            reg_rdata = cfg_q.cmd;
        end else begin
            reg_rdata = '0;
        end
    end

    irq_status_bank #(.EV_W(EV_W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_pulse),
        .clr_en_i   (clr_en_w),
        .clr_mask_i (reg_wdata[EV_W-1:0]),
        .status_o   (status_w)
    );

    irq_holdoff_timer #(.THR_W(THR_W)) i_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_i      (thr_w),
        .dly_ev_i   (|(ev_pulse & DLY_MASK)),
        .dly_pend_i (|(status_w & DLY_MASK)),
        .tick_i     (uframe_tick),
        .open_o     (open_w)
    );

    irq_line_gen #(.EV_W(EV_W), .DLY_MASK(DLY_MASK)) i_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .enable_i (enable_w),
        .open_i   (open_w),
        .irq_o    (irq_o)
    );

endmodule

module irq_coalesce_chk
    import irq_coal_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EV_W-1:0]   ev_pulse,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [EV_W-1:0]   status,
    input logic [EV_W-1:0]   enable,
    input logic              gate_open,
    input logic              irq_o
);

    // R2 and R4: an event always leaves its bit set
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse != '0) |=> ((status & $past(ev_pulse)) == $past(ev_pulse)));

    // R3: with no event and no status write, status holds
    assert_status_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse == '0 && !(reg_we && reg_addr == ADDR_W'(RSEL_STATUS))) |=> $stable(status));

    // R5: the line only rises for an enabled pending bit
    assert_irq_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((status & enable) != '0));

    // R8: while held, delayable bits alone never raise the line
    assert_held_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && (status & enable & ~DLY_MASK) == '0) |=> !irq_o);

    // R9: non-delayable enabled bits raise the line next cycle
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enable & ~DLY_MASK) != '0) |=> irq_o);

endmodule

bind irq_coalesce_ctrl irq_coalesce_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_pulse  (ev_pulse),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .status    (status_w),
    .enable    (enable_w),
    .gate_open (open_w),
    .irq_o     (irq_o)
);

// File: tb/test_irq_coalesce_ctrl.sv
module test_irq_coalesce_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  ev_pulse = '0;
    logic        uframe_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    irq_coalesce_ctrl i_irq_coalesce_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .uframe_tick(uframe_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [8:0] m);
        @(negedge clk) ev_pulse = m;
        @(negedge clk) ev_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) uframe_tick = 1'b1;
            @(negedge clk) uframe_tick = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(0, v); check("R1 status", v, 0);
        rd(1, v); check("R1 enable", v, 0);
        rd(2, v); check("R1 command", v, 0);
        check("R1 irq", irq_o, 0);
    endtask

    task automatic t_sticky_and_clear();
        logic [31:0] v;
        do_reset();
        pulse(9'h1FF);
        rd(0, v); check("R2 all bits latched", v, 32'h1FF);
        step();
        rd(0, v); check("R2 bits stay set", v, 32'h1FF);
        check("R6 no irq with enables off", irq_o, 0);
        wr(0, 32'h0);
        rd(0, v); check("R3 zero write no effect", v, 32'h1FF);
        wr(0, 32'h004);
        rd(0, v); check("R3 clear only port change", v, 32'h1FB);
        wr(0, 32'h1FB);
        rd(0, v); check("R3 clear rest", v, 32'h0);
    endtask

    task automatic t_event_beats_clear();
        logic [31:0] v;
        do_reset();
        pulse(9'h004);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h004; ev_pulse = 9'h004;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; ev_pulse = '0;
        rd(0, v); check("R4 event wins over clear", v, 32'h004);
    endtask

    task automatic t_poll_bus_reset();
        logic [31:0] v;
        do_reset();
        pulse(9'h040);
        rd(0, v); check("R6 bus reset readable", v, 32'h040);
        step();
        check("R6 disabled bit no irq", irq_o, 0);
    endtask

    task automatic t_immediate();
        do_reset();
        wr(1, 32'h002);
        pulse(9'h002);
        check("R5 irq not before register stage", irq_o, 0);
        step();
        check("R7 zero threshold immediate", irq_o, 1);
        wr(0, 32'h002);
        check("R5 irq holds one cycle after clear", irq_o, 1);
        step();
        check("R5 irq drops after clear", irq_o, 0);
    endtask

    task automatic t_holdoff();
        logic [31:0] v;
        do_reset();
        wr(2, 32'hA502_0000);
        rd(2, v); check("R7 command readback", v, 32'hA502_0000);
        wr(1, 32'h003);
        pulse(9'h001);
        step();
        check("R8 held after event", irq_o, 0);
        ticks(1);
        step();
        check("R8 held after one tick", irq_o, 0);
        ticks(1);
        step();
        check("R8 released after two ticks", irq_o, 1);
        wr(0, 32'h001);
        step(); step();
        check("R10 irq low after clear", irq_o, 0);
        pulse(9'h001);
        step();
        check("R10 new event held again", irq_o, 0);
        ticks(2);
        step();
        check("R10 new hold-off released", irq_o, 1);
    endtask

    task automatic t_bypass();
        do_reset();
        wr(2, 32'h0004_0000);
        wr(1, 32'h141);
        pulse(9'h001);
        step();
        check("R9 completion held", irq_o, 0);
        pulse(9'h100);
        step();
        check("R9 suspend bypasses hold-off", irq_o, 1);
        wr(0, 32'h100);
        step(); step();
        check("R9 completion still held", irq_o, 0);
        pulse(9'h040);
        step();
        check("R9 bus reset bypasses hold-off", irq_o, 1);
    endtask

    task automatic t_idle_ticks();
        do_reset();
        wr(2, 32'h0002_0000);
        wr(1, 32'h001);
        ticks(3);
        pulse(9'h001);
        step();
        check("R11 idle ticks not counted", irq_o, 0);
        ticks(1);
        step();
        check("R11 one tick after arming still held", irq_o, 0);
        ticks(1);
        step();
        check("R11 released after two armed ticks", irq_o, 1);
    endtask

    initial begin
        t_reset_state();
        t_sticky_and_clear();
        t_event_beats_clear();
        t_poll_bus_reset();
        t_immediate();
        t_holdoff();
        t_bypass();
        t_idle_ticks();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule